// File: doc/BRIEF.md
# Serial Receive Channel with Sticky Error Flags

This block is one receive channel of an asynchronous serial port. A character arrives on a single line as a low start bit, eight data bits sent least significant bit first, an optional parity bit and a high stop bit. The line passes through a two-flop synchronizer. A sixteen-times oversampling receiver samples each bit at its centre. The oversampling tick is produced by a programmable clock divisor. Each finished character goes into an 8-bit holding register and raises a buffer-full flag.

Software reaches the channel through a small register bus. Errors stay visible until software clears them on purpose. The usual sequence is: read the status, read the data, then write the status value back unchanged to a write-only clear register. After a framing error the receiver assumes it locked onto a false start bit. It ignores the line until software writes the stop trigger and then the start trigger. That pair resynchronises the channel with the sender. The enable state can be read back as its own register.

Top module: `rx_status_chan`

## Requirements
- R1: After reset the status register reads 0x00, the enable-status register (address 5, bit 0) reads 0 and the data register (address 0) reads 0x00.
- R2: While enabled, a well-formed character is stored in the data register and sets buffer-full. Status layout at address 1: bit 0 overrun, bit 1 parity error, bit 2 framing error, bit 5 buffer-full, all other bits 0.
- R3: A read of the data register clears buffer-full on the following clock.
- R4: A character that completes while buffer-full is set raises the overrun flag. That character is discarded and the held data is kept.
- R5: cfg_par selects the parity check: 0 or 3 means no parity bit, 1 means even, 2 means odd. A received parity bit that differs from the computed one sets the parity-error flag.
- R6: Error flags are not cleared by reading status or data. A write to the clear register (address 2) clears only the flags whose bit positions (0, 1, 2) are written as 1. Bits written as 0 leave their flags unchanged.
- R7: Writing the value read from status back to the clear register clears exactly the error flags that were set. Buffer-full and the stored data are left untouched.
- R8: A low sample at the stop-bit centre sets the framing-error flag, and the character is stored as usual. The receiver then ignores the line until the channel is stopped and restarted.
- R9: Writing 1 to bit 0 of the stop register (address 4) clears enable-status. While disabled, frames on the line are ignored.
- R10: Writing 1 to bit 0 of the start register (address 3) sets enable-status. The receiver then waits for a fresh falling edge and receives normally, which also ends a framing-error lockout.
- R11: One bit lasts 16 × cfg_div clock cycles (a divisor of 0 acts as 1). Frames at that bit time are received correctly for divisors 1 and 2.
- R12: A low pulse shorter than half a bit is rejected as a false start and does not upset the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_line | input | 1 | Asynchronous serial receive line, idle high |
| cfg_par | input | 2 | Parity mode: 0/3 none, 1 even, 2 odd |
| cfg_div | input | 8 | Clock cycles per oversampling tick |
| bus_addr | input | 3 | Register address |
| bus_wen | input | 1 | Write strobe, one cycle per access |
| bus_ren | input | 1 | Read strobe; a read of address 0 clears buffer-full |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |

## Verification
The properties assume a single register access per clock. A read and a write are never strobed together, and cfg_par and cfg_div stay fixed while a character is in flight. The bench keeps to this. Every bus access is one strobe of one cycle, driven on the falling clock edge. Configuration changes only while the line has been idle for a full bit time. Each line level is held for a whole number of bit periods, except for the deliberately short low pulse used for the false-start case.

// File: rtl/rx_status_pkg.sv
package rx_status_pkg;

   localparam int unsigned REG_AW = 3;

   localparam logic [REG_AW-1:0] A_DATA  = 3'd0;
   localparam logic [REG_AW-1:0] A_STAT  = 3'd1;
   localparam logic [REG_AW-1:0] A_CLR   = 3'd2;
   localparam logic [REG_AW-1:0] A_START = 3'd3;
   localparam logic [REG_AW-1:0] A_STOP  = 3'd4;
   localparam logic [REG_AW-1:0] A_ENST  = 3'd5;

   localparam int unsigned ST_OVR   = 0;
   localparam int unsigned ST_PER   = 1;
   localparam int unsigned ST_FER   = 2;
   localparam int unsigned ST_BFULL = 5;

   localparam logic [1:0] PAR_EVEN = 2'd1;
   localparam logic [1:0] PAR_ODD  = 2'd2;

   typedef enum logic [2:0] {
      S_IDLE  = 3'd0,
      S_START = 3'd1,
      S_DATA  = 3'd2,
      S_PAR   = 3'd3,
      S_STOP  = 3'd4,
      S_HALT  = 3'd5
   } rx_state_e;

endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("rx_line_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/rx_oversample_core.sv
module rx_oversample_core
   import rx_status_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned OSR    = 16,
   parameter int unsigned DIV_W  = 8,
   parameter bit          PAR_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              rxs,
   input  logic [1:0]        cfg_par,
   input  logic [DIV_W-1:0]  cfg_div,
   output logic              done,
   output logic [DATA_W-1:0] dout,
   output logic              perr,
   output logic              ferr
);
   localparam int unsigned OCNT_W = $clog2(OSR);
   localparam int unsigned BIDX_W = $clog2(DATA_W);
   localparam logic [OCNT_W-1:0] OCNT_MID  = OCNT_W'(OSR/2 - 1);
   localparam logic [OCNT_W-1:0] OCNT_END  = OCNT_W'(OSR - 1);
   localparam logic [BIDX_W-1:0] BIDX_LAST = BIDX_W'(DATA_W - 1);

   generate
      if (OSR < 4 || (OSR & (OSR - 1)) != 0) begin : g_bad_osr
         $error("rx_oversample_core: OSR must be a power of two, at least 4");
      end
      if (DATA_W < 2) begin : g_bad_w
         $error("rx_oversample_core: DATA_W must be at least 2");
      end
   endgenerate

   logic par_on, par_odd;
   generate
      if (PAR_EN) begin : g_par
         assign par_on  = (cfg_par == PAR_EVEN) || (cfg_par == PAR_ODD);
         assign par_odd = (cfg_par == PAR_ODD);
      end else begin : g_nopar
         assign par_on  = 1'b0;
         assign par_odd = 1'b0;
      end
   endgenerate

   rx_state_e          st;
   logic [DIV_W-1:0]   divcnt;
   logic [DIV_W-1:0]   div_eff;
   logic [OCNT_W-1:0]  ocnt;
   logic [BIDX_W-1:0]  bidx;
   logic [DATA_W-1:0]  shreg;
   logic               par_bit;
   logic               rx_prev;
   logic               busy;
   logic               tick;

   assign div_eff = (cfg_div == '0) ? DIV_W'(1) : cfg_div;
   assign busy    = (st != S_IDLE) && (st != S_HALT);
   assign tick    = busy && (divcnt == div_eff - DIV_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= S_IDLE;
         divcnt  <= '0;
         ocnt    <= '0;
         bidx    <= '0;
         shreg   <= '0;
         par_bit <= 1'b0;
         rx_prev <= 1'b1;
         done    <= 1'b0;
         dout    <= '0;
         perr    <= 1'b0;
         ferr    <= 1'b0;
      end else begin
         done    <= 1'b0;
         rx_prev <= rxs;
         if (busy) divcnt <= tick ? '0 : divcnt + DIV_W'(1);
         if (!en) begin
            st <= S_IDLE;
         end else begin
            case (st)
               S_IDLE: begin
                  if (rx_prev && !rxs) begin
                     st     <= S_START;
                     divcnt <= '0;
                     ocnt   <= '0;
                  end
               end
               S_START: if (tick) begin
                  if (ocnt == OCNT_MID) begin
                     ocnt <= '0;
                     bidx <= '0;
                     st   <= rxs ? S_IDLE : S_DATA;
                  end else begin
                     ocnt <= ocnt + 1'b1;
                  end
               end
               S_DATA: if (tick) begin
                  if (ocnt == OCNT_END) begin
                     ocnt  <= '0;
                     shreg <= {rxs, shreg[DATA_W-1:1]};
                     if (bidx == BIDX_LAST) st <= par_on ? S_PAR : S_STOP;
                     else                   bidx <= bidx + 1'b1;
                  end else begin
                     ocnt <= ocnt + 1'b1;
                  end
               end
               S_PAR: if (tick) begin
                  if (ocnt == OCNT_END) begin
                     ocnt    <= '0;
                     par_bit <= rxs;
                     st      <= S_STOP;
                  end else begin
                     ocnt <= ocnt + 1'b1;
                  end
               end
               S_STOP: if (tick) begin
                  if (ocnt == OCNT_END) begin
                     ocnt <= '0;
                     done <= 1'b1;
                     dout <= shreg;
                     perr <= par_on && (par_bit != ((^shreg) ^ par_odd));
                     ferr <= !rxs;
                     st   <= rxs ? S_IDLE : S_HALT;
                  end else begin
                     ocnt <= ocnt + 1'b1;
                  end
               end
               default: st <= S_HALT;
            endcase
         end
      end
   end
endmodule

// File: rtl/rx_status_regs.sv
module rx_status_regs
   import rx_status_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned BUS_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [REG_AW-1:0] bus_addr,
   input  logic              bus_wen,
   input  logic              bus_ren,
   input  logic [BUS_W-1:0]  bus_wdata,
   output logic [BUS_W-1:0]  bus_rdata,
   input  logic              rx_done,
   input  logic [DATA_W-1:0] rx_data,
   input  logic              rx_perr,
   input  logic              rx_ferr,
   output logic              en,
   output logic              bfull,
   output logic              ovr,
   output logic              per,
   output logic              fer,
   output logic [DATA_W-1:0] data_q
);
   generate
      if (DATA_W > BUS_W || BUS_W <= ST_BFULL) begin : g_bad
         $error("rx_status_regs: bus too narrow for data or status");
      end
   endgenerate

   logic wr_clr, wr_start, wr_stop, rd_data;
   logic load, set_ovr, set_per, set_fer;
   logic [BUS_W-1:0] stat_word;

   assign wr_clr   = bus_wen && (bus_addr == A_CLR);
   assign wr_start = bus_wen && (bus_addr == A_START) && bus_wdata[0];
   assign wr_stop  = bus_wen && (bus_addr == A_STOP)  && bus_wdata[0];
   assign rd_data  = bus_ren && (bus_addr == A_DATA);

   assign load    = rx_done && !bfull;
   assign set_ovr = rx_done && bfull;
   assign set_per = load && rx_perr;
   assign set_fer = rx_done && rx_ferr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en     <= 1'b0;
         bfull  <= 1'b0;
         ovr    <= 1'b0;
         per    <= 1'b0;
         fer    <= 1'b0;
         data_q <= '0;
      end else begin
         if (wr_start)     en <= 1'b1;
         else if (wr_stop) en <= 1'b0;

         if (load)         data_q <= rx_data;

         if (load)         bfull <= 1'b1;
         else if (rd_data) bfull <= 1'b0;

         if (set_ovr)                          ovr <= 1'b1;
         else if (wr_clr && bus_wdata[ST_OVR]) ovr <= 1'b0;

         if (set_per)                          per <= 1'b1;
         else if (wr_clr && bus_wdata[ST_PER]) per <= 1'b0;

         if (set_fer)                          fer <= 1'b1;
         else if (wr_clr && bus_wdata[ST_FER]) fer <= 1'b0;
      end
   end

   always_comb begin
      stat_word           = '0;
      stat_word[ST_OVR]   = ovr;
      stat_word[ST_PER]   = per;
      stat_word[ST_FER]   = fer;
      stat_word[ST_BFULL] = bfull;
   end

   always_comb begin
      case (bus_addr)
         A_DATA:  bus_rdata = BUS_W'(data_q);
         A_STAT:  bus_rdata = stat_word;
         A_ENST:  bus_rdata = BUS_W'(en);
         default: bus_rdata = '0;
      endcase
   end
endmodule

// File: rtl/rx_status_chan.sv
module rx_status_chan
   import rx_status_pkg::*;
#(
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned BUS_W       = 8,
   parameter int unsigned OSR         = 16,
   parameter int unsigned DIV_W       = 8,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          PAR_EN      = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_line,
   input  logic [1:0]        cfg_par,
   input  logic [DIV_W-1:0]  cfg_div,
   input  logic [REG_AW-1:0] bus_addr,
   input  logic              bus_wen,
   input  logic              bus_ren,
   input  logic [BUS_W-1:0]  bus_wdata,
   output logic [BUS_W-1:0]  bus_rdata
);
   logic              rx_sync;
   logic              rx_done, rx_perr, rx_ferr;
   logic [DATA_W-1:0] rx_data;
   logic              reg_en, reg_bfull, reg_ovr, reg_per, reg_fer;
   logic [DATA_W-1:0] reg_data;

   rx_line_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk(clk), .rst_n(rst_n), .d(rx_line), .q(rx_sync)
   );

   rx_oversample_core #(
      .DATA_W(DATA_W), .OSR(OSR), .DIV_W(DIV_W), .PAR_EN(PAR_EN)
   ) i_core (
      .clk(clk), .rst_n(rst_n), .en(reg_en), .rxs(rx_sync),
      .cfg_par(cfg_par), .cfg_div(cfg_div),
      .done(rx_done), .dout(rx_data), .perr(rx_perr), .ferr(rx_ferr)
   );

   rx_status_regs #(.DATA_W(DATA_W), .BUS_W(BUS_W)) i_regs (
      .clk(clk), .rst_n(rst_n),
      .bus_addr(bus_addr), .bus_wen(bus_wen), .bus_ren(bus_ren),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .rx_done(rx_done), .rx_data(rx_data), .rx_perr(rx_perr), .rx_ferr(rx_ferr),
      .en(reg_en), .bfull(reg_bfull), .ovr(reg_ovr), .per(reg_per), .fer(reg_fer),
      .data_q(reg_data)
   );
endmodule

// File: rtl/rx_status_chk.sv
module rx_status_chk
   import rx_status_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned BUS_W  = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic [REG_AW-1:0] bus_addr,
   input logic              bus_wen,
   input logic              bus_ren,
   input logic [BUS_W-1:0]  bus_wdata,
   input logic              rx_done,
   input logic              reg_en,
   input logic              reg_bfull,
   input logic              reg_ovr,
   input logic [DATA_W-1:0] reg_data
);
   logic rd_data, wr_start, wr_stop, clr_ovr;
   assign rd_data  = bus_ren && (bus_addr == A_DATA);
   assign wr_start = bus_wen && (bus_addr == A_START) && bus_wdata[0];
   assign wr_stop  = bus_wen && (bus_addr == A_STOP) && bus_wdata[0];
   assign clr_ovr  = bus_wen && (bus_addr == A_CLR) && bus_wdata[ST_OVR];

   AST_LOAD_SETS_FULL: assert property (@(posedge clk) disable iff (!rst_n) rx_done && !reg_bfull |=> reg_bfull); // R2
   AST_READ_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n) rd_data && !rx_done |=> !reg_bfull); // R3
   AST_OVERRUN_FLAG: assert property (@(posedge clk) disable iff (!rst_n) rx_done && reg_bfull |=> reg_ovr); // R4
   AST_OVERRUN_KEEPS: assert property (@(posedge clk) disable iff (!rst_n) rx_done && reg_bfull |=> $stable(reg_data)); // R4
   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n) reg_ovr && !clr_ovr |=> reg_ovr); // R6
   AST_STOP_DISABLES: assert property (@(posedge clk) disable iff (!rst_n) wr_stop |=> !reg_en); // R9
   AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n) !reg_en |=> !rx_done); // R9
   AST_START_ENABLES: assert property (@(posedge clk) disable iff (!rst_n) wr_start |=> reg_en); // R10
endmodule

bind rx_status_chan rx_status_chk #(.DATA_W(DATA_W), .BUS_W(BUS_W)) i_chk (
   .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wen(bus_wen),
   .bus_ren(bus_ren), .bus_wdata(bus_wdata), .rx_done(rx_done),
   .reg_en(reg_en), .reg_bfull(reg_bfull), .reg_ovr(reg_ovr), .reg_data(reg_data)
);

// File: tb/test_rx_status_chan.sv
module test_rx_status_chan;
   localparam int CLK_PERIOD = 10;
   localparam int WDOG_CYCLES = 150000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rx_line = 1'b1;
   logic [1:0] cfg_par = 2'd0;
   logic [7:0] cfg_div = 8'd1;
   logic [2:0] bus_addr = 3'd0;
   logic       bus_wen = 1'b0;
   logic       bus_ren = 1'b0;
   logic [7:0] bus_wdata = 8'd0;
   logic [7:0] bus_rdata;

   int vecs = 0;
   int errs = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   rx_status_chan i_rx_status_chan (
      .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .cfg_par(cfg_par),
      .cfg_div(cfg_div), .bus_addr(bus_addr), .bus_wen(bus_wen),
      .bus_ren(bus_ren), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
   );

   typedef struct {
      logic [7:0] data;
      logic [7:0] stat;
      string      req;
   } exp_t;
   exp_t sb[$];

   task automatic cmp(input string req, input logic [7:0] act, input logic [7:0] exp);
      vecs++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
      end
   endtask

   task automatic bus_read(input logic [2:0] a, output logic [7:0] v);
      @(negedge clk);
      bus_addr = a;
      bus_ren  = 1'b1;
      #1 v = bus_rdata;
      @(negedge clk);
      bus_ren = 1'b0;
   endtask

   task automatic bus_write(input logic [2:0] a, input logic [7:0] v);
      @(negedge clk);
      bus_addr  = a;
      bus_wdata = v;
      bus_wen   = 1'b1;
      @(negedge clk);
      bus_wen = 1'b0;
   endtask

   task automatic read_cmp(input string req, input logic [2:0] a, input logic [7:0] exp);
      logic [7:0] v;
      bus_read(a, v);
      cmp(req, v, exp);
   endtask

   task automatic drive(input logic v, input int n);
      @(negedge clk);
      rx_line = v;
      repeat (n - 1) @(negedge clk);
   endtask

   // Driver: one frame on the line; par 0 none, 1 even, 2 odd
   task automatic send_frame(input logic [7:0] d, input int par, input bit par_good,
                             input logic stop_v, input int div);
      int bt = 16 * div;
      logic p;
      drive(1'b0, bt);
      for (int i = 0; i < 8; i++) drive(d[i], bt);
      if (par != 0) begin
         p = (^d) ^ (par == 2);
         if (!par_good) p = ~p;
         drive(p, bt);
      end
      drive(stop_v, bt);
      drive(1'b1, bt);
   endtask

   task automatic expect_item(input logic [7:0] d, input logic [7:0] s, input string req);
      exp_t e;
      e.data = d;
      e.stat = s;
      e.req  = req;
      sb.push_back(e);
   endtask

   // Monitor: pops the oldest expectation and compares status then data
   task automatic monitor_pop();
      exp_t e;
      logic [7:0] v;
      if (sb.size() == 0) begin
         vecs++;
         errs++;
         $display("FAIL scoreboard: actual empty queue expected an item");
         return;
      end
      e = sb.pop_front();
      bus_read(3'd1, v);
      cmp({e.req, " status"}, v, e.stat);
      bus_read(3'd0, v);
      cmp({e.req, " data"}, v, e.data);
   endtask

   initial begin
      repeat (WDOG_CYCLES) @(posedge clk);
      if (!finished) begin
         errs++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R1 reset state
      read_cmp("R1 status", 3'd1, 8'h00);
      read_cmp("R1 enable", 3'd5, 8'h00);
      read_cmp("R1 data", 3'd0, 8'h00);

      // R10 start trigger
      bus_write(3'd3, 8'h01);
      read_cmp("R10 enable", 3'd5, 8'h01);

      // R2 / R3 plain reception
      send_frame(8'hA5, 0, 1'b1, 1'b1, 1);
      expect_item(8'hA5, 8'h20, "R2");
      monitor_pop();
      read_cmp("R3 full cleared", 3'd1, 8'h00);

      // R4 overrun, R6 sticky, R7 write-back
      send_frame(8'h3C, 0, 1'b1, 1'b1, 1);
      send_frame(8'h81, 0, 1'b1, 1'b1, 1);
      expect_item(8'h3C, 8'h21, "R4");
      monitor_pop();
      read_cmp("R6 sticky after read", 3'd1, 8'h01);
      read_cmp("R6 sticky second read", 3'd1, 8'h01);
      bus_write(3'd2, 8'h06);
      read_cmp("R6 zero bits keep flag", 3'd1, 8'h01);
      bus_write(3'd2, 8'h01);
      read_cmp("R7 writeback clears", 3'd1, 8'h00);

      // R5 even parity
      cfg_par = 2'd1;
      repeat (20) @(negedge clk);
      send_frame(8'h37, 1, 1'b1, 1'b1, 1);
      expect_item(8'h37, 8'h20, "R5 even good");
      monitor_pop();
      send_frame(8'h37, 1, 1'b0, 1'b1, 1);
      send_frame(8'h10, 1, 1'b1, 1'b1, 1);
      read_cmp("R5 even bad plus overrun", 3'd1, 8'h23);
      bus_write(3'd2, 8'h23);
      read_cmp("R7 exact clear keeps full", 3'd1, 8'h20);
      read_cmp("R4 held data", 3'd0, 8'h37);

      // R5 odd parity
      cfg_par = 2'd2;
      repeat (20) @(negedge clk);
      send_frame(8'hE1, 2, 1'b1, 1'b1, 1);
      expect_item(8'hE1, 8'h20, "R5 odd good");
      monitor_pop();
      send_frame(8'h0F, 2, 1'b0, 1'b1, 1);
      expect_item(8'h0F, 8'h22, "R5 odd bad");
      monitor_pop();
      bus_write(3'd2, 8'h02);
      read_cmp("R7 parity cleared", 3'd1, 8'h00);

      // R11 divisor 2, no parity
      cfg_par = 2'd0;
      cfg_div = 8'd2;
      repeat (40) @(negedge clk);
      send_frame(8'h5A, 0, 1'b1, 1'b1, 2);
      expect_item(8'h5A, 8'h20, "R11 div2");
      monitor_pop();
      cfg_div = 8'd1;
      repeat (20) @(negedge clk);

      // R12 false start rejection
      drive(1'b0, 4);
      drive(1'b1, 40);
      read_cmp("R12 glitch ignored", 3'd1, 8'h00);
      send_frame(8'hC3, 0, 1'b1, 1'b1, 1);
      expect_item(8'hC3, 8'h20, "R12 next frame");
      monitor_pop();

      // R8 framing error and lockout
      send_frame(8'h99, 0, 1'b1, 1'b0, 1);
      expect_item(8'h99, 8'h24, "R8 framing");
      monitor_pop();
      send_frame(8'h11, 0, 1'b1, 1'b1, 1);
      read_cmp("R8 locked out", 3'd1, 8'h04);

      // R9 stop trigger
      bus_write(3'd4, 8'h01);
      read_cmp("R9 enable cleared", 3'd5, 8'h00);
      send_frame(8'h22, 0, 1'b1, 1'b1, 1);
      read_cmp("R9 frame ignored", 3'd1, 8'h04);
      bus_write(3'd2, 8'h04);
      read_cmp("R6 framing cleared", 3'd1, 8'h00);

      // R10 restart recovers
      bus_write(3'd3, 8'h01);
      read_cmp("R10 enable set", 3'd5, 8'h01);
      send_frame(8'h77, 0, 1'b1, 1'b1, 1);
      expect_item(8'h77, 8'h20, "R10 recovered");
      monitor_pop();

      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
   end
endmodule